// File: doc/BRIEF.md
# Sound Chip Bus Write Logger

This block sits beside a two-port FM/PSG sound chip and watches its host bus without driving it: active-low chip select, active-low write strobe, the A0 port select and an 8-bit data bus. All four are treated as asynchronous. They are brought into the system clock domain, and a bus cycle is judged only at the moment chip select is released. A cycle counts as a write only if the write strobe was low while select was held, and only if select stayed low long enough to rule out a glitch.

A port-0 write (A0 low) selects a register number. Each port-1 write (A0 high) that follows is paired with the selected register to form one 16-bit record. A 256-bit mask input picks which register numbers are worth keeping. Records for other registers, such as periodic upkeep traffic, are discarded. Kept records go out on a simple SRAM-style write port at consecutive addresses starting from 1. The cycle after each record, the running record count is written to address 0. The count at address 0 is therefore valid whenever capture stops. Capture can be paused with an enable input. It halts with a sticky full flag once the last memory address holds a record.

The writer is a four-state machine. `ST_IDLE` waits for a kept record. `ST_REC` writes the record at the pointer. `ST_CNT` writes the count to address 0. `ST_FULL` is the terminal state. The transitions are:
- `ST_IDLE`→`ST_REC` on a kept record while enabled.
- `ST_REC`→`ST_CNT` always.
- `ST_CNT`→`ST_IDLE` if the record just written was not at the last address.
- `ST_CNT`→`ST_FULL` if it was.
- `ST_FULL` holds until reset.

Top module: `sndbus_logger`

## Requirements
- R1: A bus write is taken only when the synchronized chip select rises. Chip select must have been low for at least MIN_LOW system cycles, and the write strobe must have been seen low during that low phase.
- R2: A chip-select low pulse shorter than MIN_LOW cycles produces no record and changes no stored state.
- R3: A write with A0=0 sets the current register number. The number persists across any number of later data writes. A write with A0=1 forms the record word {register[7:0] in bits 15:8, data[7:0] in bits 7:0}. A data write before any register write since reset is ignored.
- R4: A record is stored only if reg_mask[register number] is 1. Records for other registers produce no memory write.
- R5: Stored records go to addresses 1, 2, 3, … in order. In the cycle after each record write, the number of records stored so far is written to address 0.
- R6: While cap_en is 0, completed records are not stored. Register selection still tracks the bus.
- R7: When a record is written at the last address (2^AW−1), full rises after the count write. Full then stays high until reset, and no further memory writes occur.
- R8: After reset, mem_we and full are 0, no memory write is issued until a record is stored, and the first record goes to address 1.
- R9: A chip-select cycle with the write strobe high (a read) produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable (1 = store records) |
| reg_mask | input | 256 | Bit n set keeps records for register n |
| bus_cs_n | input | 1 | Sound chip select, active low, asynchronous |
| bus_wr_n | input | 1 | Sound chip write strobe, active low, asynchronous |
| bus_a0 | input | 1 | Port select: 0 register number, 1 data |
| bus_d | input | 8 | Sound chip data bus |
| mem_addr | output | AW | Capture memory word address |
| mem_wdata | output | 16 | Capture memory write data |
| mem_we | output | 1 | Capture memory write enable |
| full | output | 1 | Capture memory exhausted (sticky) |

## Verification
The bench drives a table of register/data pairs. The table mixes tone and volume registers that are kept with upkeep registers that the mask rejects, so stored pairs can be told from filtered ones and the count at address 0 shows how many got through. Separate patterns cover further cases:
- A data write before any register select shows that unpaired data is dropped.
- A one-cycle select pulse separates a glitch from a real write.
- A select cycle with the strobe high separates a read from a write.
- A data write reusing the previous register number shows that the selection persists.
- Filling the memory to its last address with an extra write afterwards shows that the full flag stops the writer without overwriting anything.

// File: rtl/sndlog_pkg.sv
package sndlog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_CNT  = 2'd2,
        ST_FULL = 2'd3
    } wr_state_t;

endpackage

// File: rtl/sndlog_sync.sv
module sndlog_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_in[b];
                stab_q <= meta_q;
            end
        end
        assign sync_out[b] = stab_q;
    end
endmodule

// File: rtl/sndlog_detect.sv
module sndlog_detect #(
    parameter int DW      = 8,
    parameter int MIN_LOW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          wr_s,
    input  logic          a0_s,
    input  logic [DW-1:0] d_s,
    output logic          txn_v,
    output logic          txn_a0,
    output logic [DW-1:0] txn_d
);
    localparam int LW = $clog2(MIN_LOW + 1) + 1;

    logic          cs_d;
    logic [LW-1:0] low_cnt;
    logic          wr_seen;
    logic          snap_a0;
    logic [DW-1:0] snap_d;
    logic          cs_rise;
    logic          long_enough;

    assign cs_rise     = cs_s && !cs_d;
    assign long_enough = (low_cnt >= LW'(MIN_LOW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d    <= 1'b1;
            low_cnt <= '0;
            wr_seen <= 1'b0;
            snap_a0 <= 1'b0;
            snap_d  <= '0;
            txn_v   <= 1'b0;
            txn_a0  <= 1'b0;
            txn_d   <= '0;
        end else begin
            cs_d  <= cs_s;
            txn_v <= 1'b0;
            if (!cs_s) begin
                if (!long_enough) low_cnt <= low_cnt + 1'b1;
                if (!wr_s) begin
                    wr_seen <= 1'b1;
                    snap_a0 <= a0_s;
                    snap_d  <= d_s;
                end
            end else if (cs_rise) begin
                txn_v   <= wr_seen && long_enough;
                txn_a0  <= snap_a0;
                txn_d   <= snap_d;
                low_cnt <= '0;
                wr_seen <= 1'b0;
            end
        end
    end

    // R1: a transaction follows a select that was high in the previous cycle
    p_rise_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_v |-> $past(cs_s));

    // R2: minimum low time must hold for the pulse
    initial begin
        p_min_low_r2: assert (MIN_LOW >= 2);
    end
endmodule

// File: rtl/sndlog_pair.sv
module sndlog_pair #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_v,
    input  logic              txn_a0,
    input  logic [DW-1:0]     txn_d,
    input  logic [2**DW-1:0]  reg_mask,
    output logic              rec_v,
    output logic [2*DW-1:0]   rec_word
);
    logic [DW-1:0] reg_q;
    logic          reg_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q    <= '0;
            reg_ok   <= 1'b0;
            rec_v    <= 1'b0;
            rec_word <= '0;
        end else begin
            rec_v <= 1'b0;
            if (txn_v) begin
                if (!txn_a0) begin
                    reg_q  <= txn_d;
                    reg_ok <= 1'b1;
                end else if (reg_ok) begin
                    rec_v    <= reg_mask[reg_q];
                    rec_word <= {reg_q, txn_d};
                end
            end
        end
    end

    // R3: a record only follows a data-port transaction
    p_pair_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_v |-> $past(txn_v && txn_a0));

    // R4: a record only for a register enabled in the mask
    p_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_v |-> $past(reg_mask[reg_q]));
endmodule

// File: rtl/sndlog_writer.sv
module sndlog_writer
    import sndlog_pkg::*;
#(
    parameter int AW = 10,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          rec_v,
    input  logic [WW-1:0] rec_word,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          full
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    wr_state_t     state_q, state_n;
    logic [AW-1:0] ptr_q;
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] rec_q;
    logic          hit_last_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (rec_v && cap_en) state_n = ST_REC;
            ST_REC:  state_n = ST_CNT;
            ST_CNT:  state_n = hit_last_q ? ST_FULL : ST_IDLE;
            ST_FULL: state_n = ST_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= AW'(1);
            cnt_q      <= '0;
            rec_q      <= '0;
            hit_last_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && rec_v && cap_en) begin
                rec_q <= rec_word;
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_REC) begin
                if (ptr_q == LAST) hit_last_q <= 1'b1;
                else               ptr_q      <= ptr_q + 1'b1;
            end
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        full      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REC: begin
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = rec_q;
            end
            ST_CNT: begin
                mem_we    = 1'b1;
                mem_wdata = cnt_q;
            end
            ST_FULL: full = 1'b1;
        endcase
    end

    // R5: every record write is followed by the count write at address 0
    p_count_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != '0) |=> (mem_we && mem_addr == '0));

    // R7: full is sticky
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);

    // R7: nothing is written once full
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_we);

    // R6: a record write needs the enable in the cycle it was accepted
    p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != '0) |-> $past(cap_en));

    initial begin
        p_width_r5: assert (AW < WW);
    end
endmodule

// File: rtl/sndbus_logger.sv
module sndbus_logger #(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [2**DW-1:0]  reg_mask,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_a0,
    input  logic [DW-1:0]     bus_d,
    output logic [AW-1:0]     mem_addr,
    output logic [2*DW-1:0]   mem_wdata,
    output logic              mem_we,
    output logic              full
);
    localparam int SW = DW + 3;
    localparam logic [SW-1:0] SYNC_RST = {2'b11, 1'b0, {DW{1'b0}}};

    logic [SW-1:0]   sync_v;
    logic            txn_v;
    logic            txn_a0;
    logic [DW-1:0]   txn_d;
    logic            rec_v;
    logic [2*DW-1:0] rec_word;

    sndlog_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_wr_n, bus_a0, bus_d}),
        .sync_out (sync_v)
    );

    sndlog_detect #(.DW(DW), .MIN_LOW(MIN_LOW)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (sync_v[DW+2]),
        .wr_s   (sync_v[DW+1]),
        .a0_s   (sync_v[DW]),
        .d_s    (sync_v[DW-1:0]),
        .txn_v  (txn_v),
        .txn_a0 (txn_a0),
        .txn_d  (txn_d)
    );

    sndlog_pair #(.DW(DW)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .txn_v    (txn_v),
        .txn_a0   (txn_a0),
        .txn_d    (txn_d),
        .reg_mask (reg_mask),
        .rec_v    (rec_v),
        .rec_word (rec_word)
    );

    sndlog_writer #(.AW(AW), .WW(2*DW)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .rec_v     (rec_v),
        .rec_word  (rec_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .full      (full)
    );
endmodule

// File: tb/sndbus_logger_test.sv
module sndbus_logger_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DEPTH = 2**AW;
    localparam logic [15:0] BLANK = 16'hDEAD;

    // {register, data, kept}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h00, 8'h5A, 1'b1},
        {8'h08, 8'h0F, 1'b1},
        {8'h0E, 8'h33, 1'b0},
        {8'h01, 8'h0C, 1'b1},
        {8'h07, 8'h38, 1'b0},
        {8'h0A, 8'h07, 1'b1},
        {8'h27, 8'h15, 1'b0},
        {8'h04, 8'hA5, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b1;
    logic [255:0]  reg_mask;
    logic          bus_cs_n = 1'b1;
    logic          bus_wr_n = 1'b1;
    logic          bus_a0 = 1'b0;
    logic [7:0]    bus_d = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_we;
    logic          full;

    logic [15:0] mem [DEPTH];
    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sndbus_logger #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .reg_mask(reg_mask),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_a0(bus_a0), .bus_d(bus_d),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .full(full)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input bit a0, input logic [7:0] d, input int low, input bit wr);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_wr_n = !wr; bus_a0 = a0; bus_d = d;
        repeat (low) @(negedge clk);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] r, input logic [7:0] d);
        bus_cycle(1'b0, r, 3, 1'b1);
        bus_cycle(1'b1, d, 3, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = BLANK;
        reg_mask = '0;
        reg_mask[0] = 1'b1; reg_mask[1] = 1'b1; reg_mask[4] = 1'b1;
        reg_mask[8] = 1'b1; reg_mask[9] = 1'b1; reg_mask[10] = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(mem_we == 1'b0, "R8 we", int'(mem_we), 0);
        chk(full == 1'b0, "R8 full", int'(full), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(mem[0] == BLANK, "R8 no write", int'(mem[0]), int'(BLANK));

        // R3: data before any register select is ignored
        bus_cycle(1'b1, 8'h77, 3, 1'b1);
        chk(mem[0] == BLANK && mem[1] == BLANK, "R3 unpaired", int'(mem[1]), int'(BLANK));

        // R1 R3 R4 R5: table of register/data pairs
        for (int v = 0; v < NVEC; v++) begin
            put(VEC[v][16:9], VEC[v][8:1]);
            if (VEC[v][0]) begin
                exp_cnt++;
                chk(mem[exp_cnt] == VEC[v][16:1], "R3 R5 record", int'(mem[exp_cnt]), int'(VEC[v][16:1]));
            end else begin
                chk(mem[exp_cnt+1] == BLANK, "R4 filtered", int'(mem[exp_cnt+1]), int'(BLANK));
            end
            if (exp_cnt > 0)
                chk(mem[0] == 16'(exp_cnt), "R5 count", int'(mem[0]), exp_cnt);
        end

        // R2: glitch on select after register 8 chosen
        bus_cycle(1'b0, 8'h08, 3, 1'b1);
        bus_cycle(1'b1, 8'h11, 1, 1'b1);
        chk(mem[exp_cnt+1] == BLANK && mem[0] == 16'(exp_cnt), "R2 glitch", int'(mem[exp_cnt+1]), int'(BLANK));

        // R9: read cycle
        bus_cycle(1'b1, 8'h12, 3, 1'b0);
        chk(mem[exp_cnt+1] == BLANK, "R9 read", int'(mem[exp_cnt+1]), int'(BLANK));

        // R3: register selection persists
        bus_cycle(1'b1, 8'h22, 3, 1'b1);
        exp_cnt++;
        chk(mem[exp_cnt] == 16'h0822, "R3 persist", int'(mem[exp_cnt]), 16'h0822);
        chk(mem[0] == 16'(exp_cnt), "R5 count", int'(mem[0]), exp_cnt);

        // R6: capture paused
        cap_en = 1'b0;
        put(8'h09, 8'h44);
        chk(mem[exp_cnt+1] == BLANK && mem[0] == 16'(exp_cnt), "R6 paused", int'(mem[exp_cnt+1]), int'(BLANK));
        cap_en = 1'b1;

        // R7: fill to last address
        while (exp_cnt < DEPTH - 1) begin
            put(8'h09, 8'(exp_cnt));
            exp_cnt++;
        end
        chk(full == 1'b1, "R7 full", int'(full), 1);
        chk(mem[DEPTH-1] == {8'h09, 8'(DEPTH-2)}, "R7 last", int'(mem[DEPTH-1]), int'({8'h09, 8'(DEPTH-2)}));
        chk(mem[0] == 16'(DEPTH-1), "R7 count", int'(mem[0]), DEPTH-1);
        put(8'h0A, 8'hEE);
        chk(full == 1'b1 && mem[0] == 16'(DEPTH-1), "R7 no overwrite", int'(mem[0]), DEPTH-1);
        chk(mem[1] == 16'h005A, "R7 first kept", int'(mem[1]), 16'h005A);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule